// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Clock Divider Chain

This block derives the serial-audio bit clock and the left/right frame clock from a master audio clock. Everything runs in the master clock domain, and no derived signal ever clocks a flop. A gate bit enables the chain. Behind the gate sit two cascaded stages: a prescaler that divides by a power of two, then a linear divider that divides by an integer. Their product sets the bit period. A third divider counts bit periods to form the frame. Polarity inversion for both clocks and a frame-clock skew of up to three bit periods shape the outputs.

Software programs three control words through a plain address/write-enable/data port and can read them back. In normal use one of the two cascaded stages is left in pass-through, and the other provides the whole master-to-bit ratio. That ratio is the master-to-sample ratio divided by 64, with a frame of 64 bit periods. The gate must be closed while a divider field changes. Closing the gate clears every counter, so the first period after reopening starts cleanly on the new ratios.

Top module: `audclk_chain`

## Requirements
- R1: While the gate (word 0, bit 0) is clear, `bitTick` stays 0, `bitClk` equals the bit-invert bit and `frameClk` equals the frame-invert bit, one cycle after those bits are written.
- R2: With the gate open, the bit period is N = 2^P * (L+1) master cycles. P is word 0 bits 3:2 and L is word 1 bits 5:0. Counting cycle c=1 as the second cycle after the edge that opens the gate, `bitTick` is 1 exactly when (c-1) mod N = N-1.
- R3: With the gate open and no inversion, `bitClk` is 1 exactly when ((c-1) mod N) < floor(N/2). It is therefore 50% duty for even N and constantly 0 for N=1.
- R4: The frame lasts F = M+1 bit periods, where M is word 2 bits 11:0. Take b = floor((c-1)/N). Without skew or inversion, `frameClk` is 1 exactly when (b mod F) >= floor(F/2).
- R5: Skew S (word 0 bits 9:8) delays the frame level by S bit periods. The output follows bit index b-S, and it is 0 while b < S.
- R6: Word 0 bit 6 inverts `bitClk` and word 0 bit 7 inverts `frameClk`. Each acts as an XOR on the level.
- R7: Closing the gate clears all counters. After reopening, the outputs repeat the R2 to R5 sequence from c=1.
- R8: Reads return the stored fields at their write positions, with every other bit 0. Word 0 carries bits 0, 3:2, 6, 7 and 9:8, word 1 carries bits 5:0, word 2 carries bits 11:0, and address 3 reads 0.
- R9: After reset all words read 0 and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register word select |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr` (combinational) |
| bitTick | output | 1 | One-cycle pulse at the end of each bit period |
| bitClk | output | 1 | Registered bit-clock level |
| frameClk | output | 1 | Registered frame-clock level |

## Verification
The bench sweeps every prescaler code against several linear values (0, 1, 2, 4), so odd and even ratios from 1 to 40 are covered. Both pass-through arrangements and true cascades are among them, which separates a wrong exponent from a wrong linear count. Each ratio runs with four frame setups that rotate frame length (including F=1), skew 0 to 3 and the inversion bits, so an off-by-one in the frame half-point or the skew tap shows as a shifted edge. A run at the standard 64-bit frame, a mid-period gate close followed by a reopen, and readback with all-ones writes complete the set.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
  localparam int PRE_W  = 2;
  localparam int LIN_W  = 6;
  localparam int FRM_W  = 12;
  localparam int SKEW_W = 2;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;

  // Fixed field positions within control word 0
  localparam int EN_BIT    = 0;
  localparam int PRE_LSB   = 2;
  localparam int BINV_BIT  = 6;
  localparam int FINV_BIT  = 7;
  localparam int SKEW_LSB  = 8;

  typedef struct packed {
    logic              en;
    logic [PRE_W-1:0]  pre;
    logic [LIN_W-1:0]  lin;
    logic [FRM_W-1:0]  frm;
    logic              bitInv;
    logic              frmInv;
    logic [SKEW_W-1:0] skew;
  } divCtl_t;
endpackage

// File: rtl/audclk_regs.sv
module audclk_regs
  import audclk_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  output divCtl_t       ctl
);
  logic              enQ, bitInvQ, frmInvQ;
  logic [PRE_W-1:0]  preQ;
  logic [SKEW_W-1:0] skewQ;
  logic [LIN_W-1:0]  linQ;
  logic [FRM_W-1:0]  frmQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      bitInvQ <= 1'b0;
      frmInvQ <= 1'b0;
      preQ    <= '0;
      skewQ   <= '0;
      linQ    <= '0;
      frmQ    <= '0;
    end else if (wrEn) begin
      case (addr)
        AW'(0): begin
          enQ     <= wrData[EN_BIT];
          preQ    <= wrData[PRE_LSB +: PRE_W];
          bitInvQ <= wrData[BINV_BIT];
          frmInvQ <= wrData[FINV_BIT];
          skewQ   <= wrData[SKEW_LSB +: SKEW_W];
        end
        AW'(1): linQ <= wrData[LIN_W-1:0];
        AW'(2): frmQ <= wrData[FRM_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      AW'(0): begin
        rdData[EN_BIT]              = enQ;
        rdData[PRE_LSB +: PRE_W]    = preQ;
        rdData[BINV_BIT]            = bitInvQ;
        rdData[FINV_BIT]            = frmInvQ;
        rdData[SKEW_LSB +: SKEW_W]  = skewQ;
      end
      AW'(1): rdData[LIN_W-1:0] = linQ;
      AW'(2): rdData[FRM_W-1:0] = frmQ;
      default: rdData = '0;
    endcase
  end

  always_comb begin
    ctl.en     = enQ;
    ctl.pre    = preQ;
    ctl.lin    = linQ;
    ctl.frm    = frmQ;
    ctl.bitInv = bitInvQ;
    ctl.frmInv = frmInvQ;
    ctl.skew   = skewQ;
  end
endmodule

// File: rtl/audclk_bitdiv.sv
module audclk_bitdiv #(
  parameter int PW = 2,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          en,
  input  logic [PW-1:0] pre,
  input  logic [LW-1:0] lin,
  output logic          bitEdge,
  output logic          bitLvl
);
  localparam int MAXPRE = (1 << PW) - 1;
  localparam int PC_W   = (MAXPRE > 0) ? MAXPRE : 1;
  localparam int PH_W   = LW + MAXPRE + 1;

  logic [PC_W-1:0] preCnt;
  logic [LW-1:0]   linCnt;
  logic [PH_W-1:0] preLimit, ratio, phase;
  logic            preLast, linLast;

  always_comb begin
    preLimit = (PH_W'(1) << pre) - PH_W'(1);
    preLast  = PH_W'(preCnt) >= preLimit;
    linLast  = linCnt >= lin;
    ratio    = (PH_W'(lin) + PH_W'(1)) << pre;
    phase    = (PH_W'(linCnt) << pre) + PH_W'(preCnt);
    bitEdge  = en && preLast && linLast;
    bitLvl   = phase < (ratio >> 1);
  end

  // Prescaler stage: wraps every 2^pre cycles
  always_ff @(posedge clk) begin
    if (!rstN || !en) begin
      preCnt <= '0;
    end else if (preLast) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PC_W'(1);
    end
  end

  // Linear stage: advances once per prescaler wrap
  always_ff @(posedge clk) begin
    if (!rstN || !en) begin
      linCnt <= '0;
    end else if (preLast) begin
      if (linLast) linCnt <= '0;
      else         linCnt <= linCnt + LW'(1);
    end
  end
endmodule

// File: rtl/audclk_framediv.sv
module audclk_framediv #(
  parameter int FW = 12,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          en,
  input  logic          bitEdge,
  input  logic [FW-1:0] frm,
  input  logic [SW-1:0] skew,
  output logic          frmLvl
);
  localparam int DEPTH = (1 << SW) - 1;

  logic [FW-1:0] frmCnt;
  logic [FW:0]   half;
  logic [DEPTH:0] hist;

  always_comb begin
    half    = ({1'b0, frm} + (FW+1)'(1)) >> 1;
    hist[0] = {1'b0, frmCnt} >= half;
    frmLvl  = hist[skew];
  end

  always_ff @(posedge clk) begin
    if (!rstN || !en) begin
      frmCnt <= '0;
    end else if (bitEdge) begin
      if (frmCnt >= frm) frmCnt <= '0;
      else               frmCnt <= frmCnt + FW'(1);
    end
  end

  // Skew line: one tap per bit period of delay
  for (genvar i = 1; i <= DEPTH; i++) begin : g_skew
    always_ff @(posedge clk) begin
      if (!rstN || !en)  hist[i] <= 1'b0;
      else if (bitEdge)  hist[i] <= hist[i-1];
    end
  end
endmodule

// File: rtl/audclk_chain.sv
module audclk_chain
  import audclk_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              bitTick,
  output logic              bitClk,
  output logic              frameClk
);
  divCtl_t ctl;
  logic    bitEdge, bitLvl, frmLvl;

  audclk_regs #(.DW(DATA_W), .AW(ADDR_W)) regs_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ctl(ctl)
  );

  audclk_bitdiv #(.PW(PRE_W), .LW(LIN_W)) bitdiv_i (
    .clk(clk), .rstN(rstN), .en(ctl.en), .pre(ctl.pre), .lin(ctl.lin),
    .bitEdge(bitEdge), .bitLvl(bitLvl)
  );

  audclk_framediv #(.FW(FRM_W), .SW(SKEW_W)) frmdiv_i (
    .clk(clk), .rstN(rstN), .en(ctl.en), .bitEdge(bitEdge),
    .frm(ctl.frm), .skew(ctl.skew), .frmLvl(frmLvl)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitTick  <= 1'b0;
      bitClk   <= 1'b0;
      frameClk <= 1'b0;
    end else begin
      bitTick  <= bitEdge;
      bitClk   <= (ctl.en & bitLvl) ^ ctl.bitInv;
      frameClk <= (ctl.en & frmLvl) ^ ctl.frmInv;
    end
  end
endmodule

// File: rtl/audclk_chain_chk.sv
module audclk_chain_chk
  import audclk_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              bitTick,
  input logic              bitClk,
  input logic              frameClk,
  input divCtl_t           ctl
);
  // R1: closed gate yields no ticks and idle levels
  p_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctl.en) |-> (!bitTick && bitClk == $past(ctl.bitInv)
                        && frameClk == $past(ctl.frmInv)));

  // R2: back-to-back ticks only when the ratio is one
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && $past(bitTick)) |-> ($past(ctl.pre) == '0 && $past(ctl.lin) == '0));

  // R3: the tick falls in the low half of the bit period
  p_tick_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> (bitClk == $past(ctl.bitInv)));

  // R5: frame level only moves right after a bit-period boundary
  p_frame_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.en) && $past(ctl.en, 2)
     && $past(ctl.frmInv) == $past(ctl.frmInv, 2)
     && $past(ctl.skew) == $past(ctl.skew, 2)
     && frameClk != $past(frameClk)) |-> $past(bitTick));

  // R8: frame-length word reads back what was written
  p_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && $past(addr) == ADDR_W'(2) && addr == ADDR_W'(2))
      |-> (rdData == DATA_W'($past(wrData[FRM_W-1:0]))));
endmodule

bind audclk_chain audclk_chain_chk chk_i (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .bitTick(bitTick), .bitClk(bitClk),
  .frameClk(frameClk), .ctl(ctl)
);

// File: tb/audclk_chain_tb_top.sv
module audclk_chain_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic        bitTick, bitClk, frameClk;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  audclk_chain dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .bitTick(bitTick), .bitClk(bitClk), .frameClk(frameClk)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input int exp, input string req);
    @(negedge clk);
    addr = a;
    #1 check(req, int'(rdData), exp);
  endtask

  function automatic logic [15:0] word0(input int en, input int pre,
      input int bInv, input int fInv, input int skew);
    return 16'(en | (pre << 2) | (bInv << 6) | (fInv << 7) | (skew << 8));
  endfunction

  // Observe K cycles after the gate-opening write; compare with the arithmetic model
  task automatic observe(input int n, input int f, input int s,
      input int bInv, input int fInv, input int k);
    for (int c = 1; c <= k; c++) begin
      @(posedge clk);
      @(negedge clk);
      begin
        int j, b, ph, fb, expT, expB, expF;
        j  = c - 1;
        ph = j % n;
        b  = j / n;
        fb = b - s;
        expT = (ph == n - 1) ? 1 : 0;
        expB = ((ph < n / 2) ? 1 : 0) ^ bInv;
        expF = ((fb >= 0) ? (((fb % f) >= f / 2) ? 1 : 0) : 0) ^ fInv;
        check("R2 bitTick", int'(bitTick), expT);
        check("R3/R6 bitClk", int'(bitClk), expB);
        check("R4/R5 frameClk", int'(frameClk), expF);
      end
    end
  endtask

  task automatic runCfg(input int pre, input int lin, input int frm,
      input int skew, input int bInv, input int fInv, input int k);
    int n;
    n = (1 << pre) * (lin + 1);
    wr(2'd0, word0(0, pre, bInv, fInv, skew));
    wr(2'd1, 16'(lin));
    wr(2'd2, 16'(frm));
    rd(2'd0, int'(word0(0, pre, bInv, fInv, skew)), "R8 word0");
    rd(2'd1, lin, "R8 word1");
    @(negedge clk);
    check("R1 idle tick", int'(bitTick), 0);
    check("R1 idle bitClk", int'(bitClk), bInv);
    check("R1 idle frameClk", int'(frameClk), fInv);
    wr(2'd0, word0(1, pre, bInv, fInv, skew));
    observe(n, frm + 1, skew, bInv, fInv, k);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lins[4] = '{0, 1, 2, 4};
    int frms[4] = '{1, 2, 3, 0};
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R9: reset state
    rd(2'd0, 0, "R9 word0");
    rd(2'd1, 0, "R9 word1");
    rd(2'd2, 0, "R9 word2");
    check("R9 bitTick", int'(bitTick), 0);
    check("R9 bitClk", int'(bitClk), 0);
    check("R9 frameClk", int'(frameClk), 0);

    // R8: masking of unused bits and the empty address
    wr(2'd1, 16'hFFFF);
    rd(2'd1, 16'h003F, "R8 word1 mask");
    wr(2'd2, 16'hFFFF);
    rd(2'd2, 16'h0FFF, "R8 word2 mask");
    wr(2'd0, 16'hFFFE);
    rd(2'd0, 16'h03CC, "R8 word0 mask");
    wr(2'd3, 16'hFFFF);
    rd(2'd3, 0, "R8 empty address");
    wr(2'd0, 16'h0000);

    // R2..R6 sweep over prescaler, linear value and frame setups
    for (int p = 0; p < 4; p++) begin
      for (int li = 0; li < 4; li++) begin
        for (int q = 0; q < 4; q++) begin
          int n;
          n = (1 << p) * (lins[li] + 1);
          runCfg(p, lins[li], frms[q], q, q & 1, (q >> 1) & 1,
                 n * ((frms[q] + 1) * 2 + q + 2));
        end
      end
    end

    // R4: standard 64-bit frame, prescaler-only ratio of 2
    runCfg(1, 0, 63, 1, 0, 0, 2 * (64 * 2 + 3));

    // R7: close mid-period, stay idle, reopen and realign
    runCfg(0, 4, 2, 2, 0, 0, 7);
    wr(2'd0, word0(0, 0, 0, 0, 2));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 closed tick", int'(bitTick), 0);
      check("R7 closed bitClk", int'(bitClk), 0);
    end
    wr(2'd0, word0(1, 0, 0, 0, 2));
    observe(5, 3, 2, 0, 0, 5 * 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule